// File: doc/BRIEF.md
# Leading-One Predictor with One-Bit Correction

This block works out the normalization left-shift for a floating-point mantissa subtraction without waiting for the subtraction to finish. It takes two aligned, unsigned mantissas. An earlier swap stage has already made sure the first is not smaller than the second. From the operand bits alone it builds an indicator string and priority-encodes it, which gives a predicted leading-zero count. That prediction is either exact or one position short.

A detection network runs beside the encoder and works out from the same operand bits whether the short case has happened. The block then reports a one-bit flag and a corrected count. The corrected count equals the leading-zero count of the true difference.

A plain reference subtractor is included so that results can be compared against the real difference. Equal operands give a zero result, which is flagged and reported with a count equal to the full width. A parameter selects either a single output register stage or a purely combinational path.

Top module: `lop_predictor`

## Requirements
- R1: After reset, and before any operand pair is presented, `outValid` is 0 and `predCount`, `corrCount`, `shortByOne`, `zeroResult` and `refDiff` are all 0.
- R2: For any pair with `opA` > `opB`, `corrCount` equals the number of leading zero bits in the W-bit value `opA - opB`.
- R3: `predCount` always equals either `corrCount` or `corrCount - 1`.
- R4: `shortByOne` is 1 exactly when `predCount + 1 == corrCount`, and 0 when the two counts are equal.
- R5: When `opA == opB`, `zeroResult` is 1, `shortByOne` is 0, and `predCount` and `corrCount` both equal W.
- R6: When `opA != opB`, `zeroResult` is 0.
- R7: `refDiff` equals `opA - opB` modulo 2^W.
- R8: With `OUT_REG` = 1, the results of a pair presented with `inValid` high appear one clock later with `outValid` high. In every cycle after a clock edge at which `inValid` was low, `outValid` is 0 and all result outputs keep their previous values.
- R9: When the difference is 1, `predCount` is W-1 and `shortByOne` is 0.
- R10: When `opA` is 2^(W-1) and `opB` is 1, `predCount` is 0, `shortByOne` is 1 and `corrCount` is 1. When `opA` is 2^(W-1) and `opB` is 0, `predCount` is 0 and `shortByOne` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Operand pair on `opA`/`opB` is to be processed |
| opA | input | W | Larger aligned mantissa (minuend) |
| opB | input | W | Smaller aligned mantissa (subtrahend) |
| outValid | output | 1 | Result outputs hold a fresh result |
| predCount | output | $clog2(W+1) | Leading-zero count predicted from the indicator string |
| shortByOne | output | 1 | Prediction was one position short of the true count |
| corrCount | output | $clog2(W+1) | Corrected leading-zero count (shift amount) |
| zeroResult | output | 1 | Operands are equal and the difference is zero |
| refDiff | output | W | Reference difference `opA - opB` |

## Verification
The bench goes after the cases that sit on either side of the one-bit error. The first is a leading positive digit followed by an equal digit and a negative tail, where a design with no working correction would report a count one too small. The second is the same head with a positive or empty tail, where an over-eager correction would report one too many.

Other cases it targets:
- A difference of 1, reached through a long run of borrow digits. A wrong run-end rule would mark the first digit of the run and return a count far too small.
- Equal operands. A design without the all-zero path would report a count below W or leave the zero flag low.
- Idle cycles after a burst. A register without an enable would overwrite the held result.

// File: rtl/lop_pkg.sv
package lop_pkg;

  // Per-position strobes passed from the indicator datapath to the encoder.
  typedef struct packed {
    logic mark;  // indicator string bit: candidate leading-one position
    logic fix;   // if this mark wins, the true leading one is one lower
  } lopFlag_t;

endpackage

// File: rtl/lop_indicator.sv
module lop_indicator #(
  parameter int W = 24
) (
  input  logic                     [W-1:0] opA,
  input  logic                     [W-1:0] opB,
  output lop_pkg::lopFlag_t        [W-1:0] flags,
  output logic                     [W-1:0] refDiff
);

  // Signed-digit view of A - B: each position is +1, -1 or 0.
  logic [W-1:0] isPos;
  logic [W-1:0] isNeg;
  logic [W-1:0] nonZero;

  // negBelow[i]: the nearest non-zero digit below position i is -1.
  logic [W:0]   negBelow;

  assign isPos   = opA & ~opB;
  assign isNeg   = ~opA & opB;
  assign nonZero = opA ^ opB;

  assign negBelow[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_chain
    assign negBelow[i+1] = isNeg[i] | (~isPos[i] & negBelow[i]);
  end

  // Position 0 has no lower neighbour: a non-zero digit there always marks.
  assign flags[0].mark = nonZero[0];
  assign flags[0].fix  = 1'b0;

  for (genvar i = 1; i < W; i++) begin : g_flag
    // A non-zero digit that is not followed by a -1 ends the leading run.
    assign flags[i].mark = nonZero[i] & ~isNeg[i-1];
    // A zero digit next, then a negative tail, pulls the value below 2^i.
    assign flags[i].fix  = nonZero[i] & ~nonZero[i-1] & negBelow[i-1];
  end

  // Reference subtractor, used for comparison only.
  assign refDiff = opA - opB;

endmodule

// File: rtl/lop_encoder.sv
module lop_encoder #(
  parameter int W  = 24,
  parameter int CW = $clog2(W + 1)
) (
  input  lop_pkg::lopFlag_t [W-1:0] flags,
  output logic              [CW-1:0] predCount,
  output logic                      shortByOne,
  output logic              [CW-1:0] corrCount,
  output logic                      zeroResult
);

  logic [W:0]    seenAbove;
  logic [W-1:0]  oneHot;
  logic [W-1:0]  fixVec;
  logic [CW-1:0] posCount;

  assign seenAbove[W] = 1'b0;

  for (genvar i = W - 1; i >= 0; i--) begin : g_pri
    assign seenAbove[i] = seenAbove[i+1] | flags[i].mark;
    assign oneHot[i]    = flags[i].mark & ~seenAbove[i+1];
    assign fixVec[i]    = flags[i].fix;
  end

  always_comb begin
    posCount = '0;
    for (int i = 0; i < W; i++) begin
      if (oneHot[i]) posCount = posCount | CW'(W - 1 - i);
    end
  end

  assign zeroResult = ~seenAbove[0];
  assign predCount  = zeroResult ? CW'(W) : posCount;
  // Correction is selected by the same one-hot, in parallel with the count.
  assign shortByOne = |(oneHot & fixVec);
  assign corrCount  = predCount + CW'(shortByOne);

endmodule

// File: rtl/lop_predictor.sv
module lop_predictor #(
  parameter int W       = 24,
  parameter int OUT_REG = 1,
  localparam int CW     = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [W-1:0]  opA,
  input  logic [W-1:0]  opB,
  output logic          outValid,
  output logic [CW-1:0] predCount,
  output logic          shortByOne,
  output logic [CW-1:0] corrCount,
  output logic          zeroResult,
  output logic [W-1:0]  refDiff
);

  lop_pkg::lopFlag_t [W-1:0] flags;
  logic [W-1:0]  diffC;
  logic [CW-1:0] predC;
  logic [CW-1:0] corrC;
  logic          shortC;
  logic          zeroC;

  lop_indicator #(.W(W)) uInd (
    .opA     (opA),
    .opB     (opB),
    .flags   (flags),
    .refDiff (diffC)
  );

  lop_encoder #(.W(W), .CW(CW)) uEnc (
    .flags      (flags),
    .predCount  (predC),
    .shortByOne (shortC),
    .corrCount  (corrC),
    .zeroResult (zeroC)
  );

  if (OUT_REG != 0) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outValid   <= 1'b0;
        predCount  <= '0;
        shortByOne <= 1'b0;
        corrCount  <= '0;
        zeroResult <= 1'b0;
        refDiff    <= '0;
      end else begin
        outValid <= inValid;
        if (inValid) begin
          predCount  <= predC;
          shortByOne <= shortC;
          corrCount  <= corrC;
          zeroResult <= zeroC;
          refDiff    <= diffC;
        end
      end
    end

    // R8: an idle input cycle leaves the results untouched.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
      !inValid |=> !outValid && $stable(corrCount) && $stable(predCount)
                   && $stable(refDiff));
  end else begin : g_comb
    assign outValid   = inValid;
    assign predCount  = predC;
    assign shortByOne = shortC;
    assign corrCount  = corrC;
    assign zeroResult = zeroC;
    assign refDiff    = diffC;
  end

  // Leading-zero count of the reference difference, for the checks below.
  function automatic logic [CW-1:0] lzcRef(input logic [W-1:0] v);
    logic [CW-1:0] n;
    logic          hit;
    n   = '0;
    hit = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!hit && v[i]) hit = 1'b1;
      if (!hit) n = n + 1'b1;
    end
    return n;
  endfunction

  // R2: corrected count agrees with the subtractor's true leading zeros.
  a_r2_corr_matches_ref: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> corrCount == lzcRef(refDiff));

  // R3: the prediction is never too long and at most one short.
  a_r3_pred_window: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (predCount == lzcRef(refDiff))
                 || ({1'b0, predCount} + 1'b1 == {1'b0, lzcRef(refDiff)}));

  // R4: the short flag only appears on a non-zero result with room to move.
  a_r4_short_flag: assert property (@(posedge clk) disable iff (!rstN)
    outValid && shortByOne |-> !zeroResult && refDiff != '0
                               && corrCount != '0);

  // R5: equal operands report a full-width count.
  a_r5_zero_counts: assert property (@(posedge clk) disable iff (!rstN)
    outValid && zeroResult |-> refDiff == '0 && corrCount == CW'(W)
                               && predCount == CW'(W) && !shortByOne);

  // R6: any non-zero difference clears the zero flag.
  a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rstN)
    outValid && refDiff != '0 |-> !zeroResult);

endmodule

// File: tb/lop_predictor_test.sv
module lop_predictor_test;

  localparam int W  = 24;
  localparam int CW = $clog2(W + 1);
  localparam logic [W-1:0] MSB = {1'b1, {(W-1){1'b0}}};

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    int           lz;
    int           pred;    // exact expected prediction, -1 when not fixed
    int           short1;  // exact expected short flag, -1 when not fixed
  } expItem_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [W-1:0]  opA = '0;
  logic [W-1:0]  opB = '0;
  logic          outValid;
  logic [CW-1:0] predCount;
  logic          shortByOne;
  logic [CW-1:0] corrCount;
  logic          zeroResult;
  logic [W-1:0]  refDiff;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  expItem_t sb[$];

  always #10 clk = ~clk;  // 50 MHz

  lop_predictor #(.W(W), .OUT_REG(1)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .outValid(outValid), .predCount(predCount), .shortByOne(shortByOne),
    .corrCount(corrCount), .zeroResult(zeroResult), .refDiff(refDiff)
  );

  task automatic chk(input bit ok, input string tag, input longint act,
                     input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int benchLz(input logic [W-1:0] v);
    for (int i = W - 1; i >= 0; i--) if (v[i]) return W - 1 - i;
    return W;
  endfunction

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                       input int pred, input int short1);
    expItem_t e;
    @(negedge clk);
    opA = a;
    opB = b;
    inValid = 1'b1;
    e.a = a; e.b = b; e.lz = benchLz(a - b);
    e.pred = pred; e.short1 = short1;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid = 1'b0;
      opA = opA ^ {W{1'b1}};  // changing operands must not leak through
    end
  endtask

  // Monitor: pop expected items as results appear.
  int lastCorr = 0;
  int lastPred = 0;
  bit haveLast = 1'b0;
  always @(posedge clk) begin
    #2;
    if (rstN && outValid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R8 unexpected outValid", 1, 0);
      end else begin
        expItem_t e;
        e = sb.pop_front();
        chk(int'(corrCount) == e.lz, "R2 corrCount", corrCount, e.lz);
        chk(int'(predCount) == e.lz || int'(predCount) + 1 == e.lz,
            "R3 predCount window", predCount, e.lz);
        chk(int'(corrCount) == int'(predCount) + int'(shortByOne),
            "R4 short flag vs counts", shortByOne,
            int'(corrCount) - int'(predCount));
        chk(refDiff == e.a - e.b, "R7 refDiff", refDiff, e.a - e.b);
        if (e.a == e.b) begin
          chk(zeroResult == 1'b1 && int'(predCount) == W,
              "R5 zero operands", predCount, W);
        end else begin
          chk(zeroResult == 1'b0, "R6 zeroResult low", zeroResult, 0);
        end
        if (e.pred >= 0)
          chk(int'(predCount) == e.pred, "R9/R10 exact prediction",
              predCount, e.pred);
        if (e.short1 >= 0)
          chk(int'(shortByOne) == e.short1, "R9/R10 exact short flag",
              shortByOne, e.short1);
        lastCorr = corrCount;
        lastPred = predCount;
        haveLast = 1'b1;
      end
    end else if (rstN && haveLast) begin
      chk(int'(corrCount) == lastCorr && int'(predCount) == lastPred,
          "R8 hold while idle", corrCount, lastCorr);
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state.
    chk(outValid == 1'b0, "R1 outValid in reset", outValid, 0);
    chk(corrCount == '0 && predCount == '0 && refDiff == '0,
        "R1 counts in reset", corrCount, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0 && zeroResult == 1'b0 && shortByOne == 1'b0,
        "R1 idle after reset", outValid, 0);

    // Corner cases.
    drive(MSB, 1, 0, 1);                  // R10 short by one
    drive(MSB, 0, 0, 0);                  // R10 exact
    drive(MSB, MSB - 1, W - 1, 0);        // R9 difference of 1
    drive(24'h000123, 24'h000122, W - 1, 0);  // R9
    drive({W{1'b1}}, {W{1'b1}}, W, 0);    // R5 equal
    drive(0, 0, W, 0);                    // R5 equal at zero
    drive(24'h123456, 24'h123456, W, 0);  // R5
    drive({W{1'b1}}, 0, 0, 0);
    drive(24'h100000, 24'h000001, -1, -1);
    drive(24'h008000, 24'h004001, -1, -1);
    drive(24'h0C0000, 24'h040001, -1, -1);
    idle(4);                              // R8 hold

    // Short-by-one sweep: 2^k - 1 has leading one at k-1.
    for (int k = 1; k < W; k++) drive(W'(1) << k, 1, -1, -1);
    // Exact sweep: head digit with zero tail.
    for (int k = 0; k < W; k++) drive(W'(1) << k, 0, -1, 0);
    idle(3);

    // Random pairs with varied magnitude.
    for (int n = 0; n < 600; n++) begin
      logic [W-1:0] a, b, t;
      a = W'($urandom) >> ($urandom % W);
      b = W'($urandom) >> ($urandom % W);
      if (n % 7 == 0) b = a - W'($urandom % 4);
      if (a < b) begin t = a; a = b; b = t; end
      drive(a, b, -1, -1);
      if (n % 50 == 49) idle(2);
    end
    idle(4);
    chk(sb.size() == 0, "R8 all results delivered", sb.size(), 0);
    finishRun();
  end

endmodule